// File: doc/BRIEF.md
# Packet Serial Transmitter with Half-Duplex Driver Control

This block sends asynchronous serial characters grouped into frames. A host writes payload bytes into a data FIFO and frame lengths into a frame queue. A frame is sent only once all of its bytes are present. The bytes of a frame go out back to back. Successive frames are separated by a programmable idle gap, counted in bit times.

Bit timing comes from a 24-bit phase accumulator. The host programs an increment equal to bitrate × 2^24 / f_clk, and each carry out of the accumulator ends one bit. A second output controls an external RS-422/485 line driver. The driver can be held on or off by a manual bit. In automatic mode the block raises the driver a programmed number of clocks before the first start bit and drops it once the last stop bit of the frame has ended.

Register port (write and read are independent):

- Address 0 (write): data byte, bits 7..0.
- Address 1 (write): frame length in bytes, bits 4..0.
- Address 2 (read/write): increment, bits 23..0.
- Address 3 (write): mode word, or a clear command when bit 31 is set.
- Address 3 (read): status. Configuration fields read back where they were written; the parity fields read back as the frame count.

Top module: `pkt_uart_tx`

## Requirements
- R1: After reset, tx_o is 1, drv_en_o is 0, and the status word and the increment read 0.
- R2: Each bit on tx_o lasts until the 24-bit accumulator carries. The accumulator starts from 0 at the first start bit of a frame, adds the increment every clock, and runs on without reset across the characters and the gap of that frame. An increment of 2^21 gives 8 clocks per bit.
- R3: Each character is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. The line idles at 1.
- R4: Mode bit 17 inserts a parity bit after the data bits. Mode bit 18 selects odd parity when 1 and even parity when 0.
- R5: A frame starts only when the data FIFO holds at least the frame's length. It pops its length entry when it starts.
- R6: Mode bits 15..8 (N) hold tx_o at 1 for N bit times after a frame's last stop bit. Busy stays set during this gap, and no frame starts until the gap has passed.
- R7: When mode bit 5 is 0, drv_en_o follows mode bit 6. When mode bit 5 is 1, bit 6 has no effect.
- R8: In automatic mode (bit 5 = 1), drv_en_o rises exactly D clocks before the first start bit, where D is mode bits 3..0, and falls on the clock after the last stop bit ends. With D = 0 it rises together with the start bit.
- R9: Status bit 7 is busy, bits 20..16 are the number of queued frame entries, and bit 21 is 1 when the data FIFO is not empty. Bits 3..0, 5, 6 and 15..8 read back the mode fields.
- R10: A write into a full data FIFO or a full frame queue is dropped and sets status bit 4. The bit stays set until a clear.
- R11: A mode write with bit 31 set (for example 0x80010000) empties both FIFOs, aborts any frame in flight (tx_o 1, not busy), clears the error bit, and leaves the configuration unchanged.
- R12: A frame-length entry of 0 is removed from the queue without driving the line or setting busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data (combinational from rd_addr_i) |
| tx_o | output | 1 | Serial data, idles high |
| drv_en_o | output | 1 | External line driver enable |

## Verification
The assertions check on every cycle that:

- a bit level stays stable between accumulator carries;
- the idle gap holds until its count expires;
- the driver is raised together with the lead phase;
- a clear empties both FIFOs and ends busy on the next clock;
- the FIFOs are never pushed when full or popped when empty.

Only the bench's scenarios can show the complete character and parity sequence, the exact lead count, gap lengths, error stickiness and the discarding of zero-length entries. The bench's reference model predicts tx_o, drv_en_o and the read data on every clock for those scenarios.

// File: rtl/pkt_uart_tx_pkg.sv
`timescale 1ns/1ps
package pkt_uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_GAP
  } ptx_state_e;

  typedef struct packed {
    logic       par_odd;
    logic       par_en;
    logic [7:0] gap;
    logic       de_man;
    logic       de_auto;
    logic [3:0] de_lead;
  } ptx_mode_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_FLEN = 2'd1;
  localparam logic [1:0] ADDR_RATE = 2'd2;
  localparam logic [1:0] ADDR_MODE = 2'd3;
endpackage

// File: rtl/ptx_fifo.sv
`timescale 1ns/1ps
module ptx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign count_o = cnt;
  assign dout_o  = mem[rptr];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end

  // R10
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R5
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ptx_baud.sv
`timescale 1ns/1ps
module ptx_baud #(
  parameter int ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc} + {1'b0, inc_i};
  assign tick_o = run_i && sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc <= '0;
    else if (run_i) acc <= sum[ACC_W-1:0];
    else            acc <= '0;
  end
endmodule

// File: rtl/ptx_engine.sv
`timescale 1ns/1ps
module ptx_engine
  import pkt_uart_tx_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  ptx_mode_t        mode_i,
  input  logic             tick_i,
  output logic             run_o,
  input  logic             frm_empty_i,
  input  logic [LEN_W-1:0] frm_len_i,
  output logic             frm_pop_o,
  input  logic [LEN_W-1:0] data_count_i,
  input  logic [7:0]       data_i,
  output logic             data_pop_o,
  output logic             tx_o,
  output logic             drv_en_o,
  output logic             busy_o
);
  ptx_state_e state;
  logic [3:0]       lead_cnt;
  logic [7:0]       gap_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             par_bit;
  logic [LEN_W-1:0] bytes_left;
  logic frm_ok, lead_needed, start_chr;

  assign frm_ok      = !frm_empty_i && (frm_len_i == '0 || data_count_i >= frm_len_i);
  assign lead_needed = mode_i.de_auto && (mode_i.de_lead != 4'd0);
  assign frm_pop_o   = !clr_i && (state == ST_IDLE) && frm_ok;
  assign start_chr   = !clr_i && (
      (state == ST_IDLE && frm_ok && frm_len_i != '0 && !lead_needed) ||
      (state == ST_LEAD && lead_cnt == 4'd1) ||
      (state == ST_STOP && tick_i && bytes_left != LEN_W'(1)));
  assign data_pop_o  = start_chr;

  assign run_o  = state inside {ST_START, ST_DATA, ST_PAR, ST_STOP, ST_GAP};
  assign busy_o = (state != ST_IDLE);
  assign drv_en_o = mode_i.de_auto
                  ? (state inside {ST_LEAD, ST_START, ST_DATA, ST_PAR, ST_STOP})
                  : mode_i.de_man;

  always_comb begin
    case (state)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = shreg[0];
      ST_PAR:   tx_o = par_bit;
      default:  tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      lead_cnt   <= '0;
      gap_cnt    <= '0;
      bit_cnt    <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      bytes_left <= '0;
    end else if (clr_i) begin
      state <= ST_IDLE;
    end else begin
      if (start_chr) begin
        shreg   <= data_i;
        par_bit <= (^data_i) ^ mode_i.par_odd;
        state   <= ST_START;
      end
      case (state)
        ST_IDLE: if (frm_pop_o && frm_len_i != '0) begin
          bytes_left <= frm_len_i;
          if (lead_needed) begin
            state    <= ST_LEAD;
            lead_cnt <= mode_i.de_lead;
          end
        end
        ST_LEAD: if (lead_cnt != 4'd1) lead_cnt <= lead_cnt - 4'd1;
        ST_START: if (tick_i) begin
          state   <= ST_DATA;
          bit_cnt <= '0;
        end
        ST_DATA: if (tick_i) begin
          shreg   <= shreg >> 1;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) state <= mode_i.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (tick_i) state <= ST_STOP;
        ST_STOP: if (tick_i) begin
          if (bytes_left == LEN_W'(1)) begin
            state   <= (mode_i.gap != 8'd0) ? ST_GAP : ST_IDLE;
            gap_cnt <= mode_i.gap;
          end else begin
            bytes_left <= bytes_left - LEN_W'(1);
          end
        end
        ST_GAP: if (tick_i) begin
          if (gap_cnt == 8'd1) state <= ST_IDLE;
          else gap_cnt <= gap_cnt - 8'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state inside {ST_START, ST_DATA, ST_PAR, ST_STOP} && !tick_i && !clr_i) |=> $stable(tx_o));
  // R6
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_GAP && !tick_i && !clr_i) |=> (state == ST_GAP && tx_o));
  // R8
  lead_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_pop_o && frm_len_i != '0 && lead_needed) |=> (drv_en_o && tx_o && busy_o));
endmodule

// File: rtl/pkt_uart_tx.sv
`timescale 1ns/1ps
module pkt_uart_tx
  import pkt_uart_tx_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int FRM_DEPTH  = 16,
  parameter int ACC_W      = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        tx_o,
  output logic        drv_en_o
);
  localparam int LEN_W = $clog2(DATA_DEPTH + 1);
  localparam int FCW   = $clog2(FRM_DEPTH + 1);

  ptx_mode_t        mode_q;
  logic [ACC_W-1:0] inc_q;
  logic             err_q;
  logic             clr, wr_dat, wr_len;
  logic             d_full, d_empty, d_pop, f_full, f_empty, f_pop;
  logic [7:0]       d_out;
  logic [LEN_W-1:0] d_cnt, f_len;
  logic [FCW-1:0]   f_cnt;
  logic             tick, run, busy;
  logic             unused_wr;

  assign clr    = wr_en_i && wr_addr_i == ADDR_MODE && wr_data_i[31];
  assign wr_dat = wr_en_i && wr_addr_i == ADDR_DATA;
  assign wr_len = wr_en_i && wr_addr_i == ADDR_FLEN;
  assign unused_wr = ^{wr_data_i[30:19], wr_data_i[16], wr_data_i[7], wr_data_i[4]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      inc_q  <= '0;
      err_q  <= 1'b0;
    end else if (clr) begin
      err_q <= 1'b0;
    end else begin
      if ((wr_dat && d_full) || (wr_len && f_full)) err_q <= 1'b1;
      if (wr_en_i && wr_addr_i == ADDR_RATE) inc_q <= wr_data_i[ACC_W-1:0];
      if (wr_en_i && wr_addr_i == ADDR_MODE) begin
        mode_q.par_odd <= wr_data_i[18];
        mode_q.par_en  <= wr_data_i[17];
        mode_q.gap     <= wr_data_i[15:8];
        mode_q.de_man  <= wr_data_i[6];
        mode_q.de_auto <= wr_data_i[5];
        mode_q.de_lead <= wr_data_i[3:0];
      end
    end
  end

  ptx_fifo #(.WIDTH(8), .DEPTH(DATA_DEPTH)) u_data (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(wr_dat && !d_full), .din_i(wr_data_i[7:0]),
    .pop_i(d_pop), .dout_o(d_out),
    .full_o(d_full), .empty_o(d_empty), .count_o(d_cnt)
  );

  ptx_fifo #(.WIDTH(LEN_W), .DEPTH(FRM_DEPTH)) u_frm (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(wr_len && !f_full), .din_i(wr_data_i[LEN_W-1:0]),
    .pop_i(f_pop), .dout_o(f_len),
    .full_o(f_full), .empty_o(f_empty), .count_o(f_cnt)
  );

  ptx_baud #(.ACC_W(ACC_W)) u_baud (
    .clk_i, .rst_ni, .run_i(run), .inc_i(inc_q), .tick_o(tick)
  );

  ptx_engine #(.LEN_W(LEN_W)) u_eng (
    .clk_i, .rst_ni, .clr_i(clr), .mode_i(mode_q), .tick_i(tick), .run_o(run),
    .frm_empty_i(f_empty), .frm_len_i(f_len), .frm_pop_o(f_pop),
    .data_count_i(d_cnt), .data_i(d_out), .data_pop_o(d_pop),
    .tx_o, .drv_en_o, .busy_o(busy)
  );

  always_comb begin
    case (rd_addr_i)
      ADDR_RATE: rd_data_o = 32'(inc_q);
      ADDR_MODE: rd_data_o = {10'd0, !d_empty, 5'(f_cnt), mode_q.gap, busy,
                              mode_q.de_man, mode_q.de_auto, err_q, mode_q.de_lead};
      default:   rd_data_o = '0;
    endcase
  end

  // R11
  clear_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!busy && f_empty && d_empty && !err_q && tx_o));
  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr) |=> err_q);
endmodule

// File: tb/tb_pkt_uart_tx.sv
`timescale 1ns/1ps
module tb_pkt_uart_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = 2'd3;
  logic [31:0] wr_data = '0, rd_data;
  logic tx, drv;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string scen = "R3";

  always #2.5 clk = ~clk;

  pkt_uart_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tx_o(tx), .drv_en_o(drv)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  byte unsigned m_data[$];
  int m_frm[$];
  bit m_bits[$];
  int m_phase, m_acc, m_lead, m_gap, m_left, m_inc, m_delay, m_gapcfg;
  bit m_err, m_auto, m_man, m_pen, m_podd;

  function automatic void m_load();
    byte unsigned b = m_data.pop_front();
    m_bits.delete();
    m_bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) m_bits.push_back(b[i]);
    if (m_pen) m_bits.push_back((^b) ^ m_podd);
    m_bits.push_back(1'b1);
    m_phase = 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data.delete(); m_frm.delete(); m_bits.delete();
      m_phase = 0; m_acc = 0; m_inc = 0; m_delay = 0; m_gapcfg = 0;
      m_err = 0; m_auto = 0; m_man = 0; m_pen = 0; m_podd = 0;
    end else if (wr_en && wr_addr == 2'd3 && wr_data[31]) begin
      m_data.delete(); m_frm.delete(); m_phase = 0; m_acc = 0; m_err = 0;
    end else begin
      case (m_phase)
        0: if (m_frm.size() > 0) begin
          if (m_frm[0] == 0) void'(m_frm.pop_front());
          else if (m_data.size() >= m_frm[0]) begin
            m_left = m_frm.pop_front();
            if (m_auto && m_delay != 0) begin m_phase = 1; m_lead = m_delay; end
            else m_load();
          end
        end
        1: if (m_lead == 1) m_load(); else m_lead--;
        default: begin
          m_acc += m_inc;
          if (m_acc >= (1 << 24)) begin
            m_acc -= (1 << 24);
            if (m_phase == 2) begin
              void'(m_bits.pop_front());
              if (m_bits.size() == 0) begin
                if (m_left == 1) begin
                  if (m_gapcfg != 0) begin m_phase = 3; m_gap = m_gapcfg; end
                  else begin m_phase = 0; m_acc = 0; end
                end else begin m_left--; m_load(); end
              end
            end else begin
              if (m_gap == 1) begin m_phase = 0; m_acc = 0; end
              else m_gap--;
            end
          end
        end
      endcase
      if (wr_en) case (wr_addr)
        2'd0: if (m_data.size() == 16) m_err = 1; else m_data.push_back(wr_data[7:0]);
        2'd1: if (m_frm.size() == 16) m_err = 1; else m_frm.push_back(int'(wr_data[4:0]));
        2'd2: m_inc = int'(wr_data[23:0]);
        default: begin
          m_podd = wr_data[18]; m_pen = wr_data[17]; m_gapcfg = int'(wr_data[15:8]);
          m_man = wr_data[6]; m_auto = wr_data[5]; m_delay = int'(wr_data[3:0]);
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({scen, " tx"}, 32'(tx), (m_phase == 2) ? 32'(m_bits[0]) : 32'd1);
      chk("R7/R8 drv", 32'(drv),
          m_auto ? 32'(m_phase == 1 || m_phase == 2) : 32'(m_man));
      if (rd_addr == 2'd3)
        chk("R9 status", rd_data, {10'd0, m_data.size() != 0, 5'(m_frm.size()),
            8'(m_gapcfg), m_phase != 0, m_man, m_auto, m_err, 4'(m_delay)});
      else if (rd_addr == 2'd2)
        chk("R2 rate", rd_data, 32'(m_inc));
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] mw(int dly, bit au, bit mn, int gap, bit pe, bit po);
    return {13'd0, po, pe, 1'b0, 8'(gap), 1'b0, mn, au, 1'b0, 4'(dly)};
  endfunction

  task automatic wait_idle();
    do @(negedge clk); while (!(m_phase == 0 && m_frm.size() == 0));
    repeat (3) @(negedge clk);
  endtask

  task automatic send(int n, byte unsigned b0);
    for (int i = 0; i < n; i++) wr(2'd0, 32'(b0 + 8'(i * 37)));
    wr(2'd1, 32'(n));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx", 32'(tx), 1);
    chk("R1 drv", 32'(drv), 0);
    chk("R1 status", rd_data, 0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1 rd_addr = 2'd2;
    @(negedge clk);
    chk("R1 rate", rd_data, 0);
    #1 rd_addr = 2'd3;

    // R3 framing at 8 clocks per bit
    wr(2'd2, 32'h20_0000);
    send(1, 8'hA5);
    wait_idle();
    send(3, 8'h3C);
    wait_idle();

    // R2 start bit length with 0xFF payload
    scen = "R2";
    send(1, 8'hFF);
    do @(negedge clk); while (tx);
    cnt = 0;
    while (!tx) begin cnt++; @(negedge clk); end
    chk("R2 start bit clocks", 32'(cnt), 8);
    wait_idle();
    wr(2'd2, 32'h2A_AAAB);
    send(2, 8'h5A);
    wait_idle();

    // R4 parity even then odd
    scen = "R4";
    wr(2'd3, mw(0, 0, 0, 0, 1, 0));
    send(2, 8'h01);
    wait_idle();
    wr(2'd3, mw(0, 0, 0, 0, 1, 1));
    send(2, 8'h07);
    wait_idle();

    // R6 gap between frames
    scen = "R6";
    wr(2'd2, 32'h20_0000);
    wr(2'd3, mw(0, 0, 0, 3, 0, 0));
    send(1, 8'h11);
    send(1, 8'h22);
    wait_idle();

    // R5 frame waits for its bytes
    scen = "R5";
    wr(2'd3, mw(0, 0, 0, 0, 0, 0));
    wr(2'd0, 32'h44);
    wr(2'd1, 32'd2);
    repeat (40) @(negedge clk);
    chk("R5 busy while short", 32'(rd_data[7]), 0);
    chk("R5 tx while short", 32'(tx), 1);
    wr(2'd0, 32'h55);
    wait_idle();

    // R7 manual and overridden driver enable
    scen = "R7";
    wr(2'd3, mw(0, 0, 1, 0, 0, 0));
    @(negedge clk);
    chk("R7 manual on", 32'(drv), 1);
    wr(2'd3, mw(0, 1, 1, 0, 0, 0));
    @(negedge clk);
    chk("R7 auto overrides", 32'(drv), 0);

    // R8 lead time and release
    scen = "R8";
    wr(2'd3, mw(5, 1, 0, 2, 0, 0));
    send(2, 8'h81);
    do @(negedge clk); while (!drv);
    cnt = 0;
    while (tx) begin cnt++; @(negedge clk); end
    chk("R8 lead clocks", 32'(cnt), 5);
    wait_idle();
    wr(2'd3, mw(0, 1, 0, 0, 1, 1));
    send(2, 8'hC3);
    wait_idle();

    // R12 zero-length entry
    scen = "R12";
    wr(2'd1, 32'd0);
    repeat (3) @(negedge clk);
    chk("R12 queue drained", 32'(rd_data[20:16]), 0);
    chk("R12 not busy", 32'(rd_data[7]), 0);

    // R10 overflow sets sticky error
    scen = "R10";
    for (int i = 0; i < 17; i++) wr(2'd0, 32'(i));
    repeat (4) @(negedge clk);
    chk("R10 error set", 32'(rd_data[4]), 1);

    // R11 clear keeps config
    scen = "R11";
    wr(2'd3, 32'h8001_0000);
    @(negedge clk);
    chk("R11 error cleared", 32'(rd_data[4]), 0);
    chk("R11 data empty", 32'(rd_data[21]), 0);
    chk("R11 auto kept", 32'(rd_data[5]), 1);
    send(3, 8'h96);
    repeat (30) @(negedge clk);
    wr(2'd3, 32'h8001_0000);
    @(negedge clk);
    chk("R11 abort busy", 32'(rd_data[7]), 0);
    chk("R11 abort tx", 32'(tx), 1);
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule